// File: doc/BRIEF.md
# Transition-Mode PFC Gate Controller

This block drives the switch gate of a boost power-factor stage that runs in transition mode. It starts each switching period when the boost inductor has demagnetized. It ends the period when the sensed switch current reaches the reference that the analog multiplier sets. All analog decisions are made outside the block and arrive as single-bit comparator flags sampled by the block clock.

A demagnetization event is an armed falling edge of the zero-current flag. The flag arms on its rising edge and fires on the falling edge that follows. After turn-on, the current-reference flag is ignored for a short blanking window, so that the discharge spike at the leading edge cannot end the on-time early. A cap on the on-time covers a current-reference flag that never asserts. When switching stalls, a restart timer issues turn-on events on its own. The timer is cleared by every turn-on.

Three stop conditions force the gate low at the next edge: the saturation-level current flag, the dynamic over-voltage flag, and a low enable. None of them latches. Once the condition clears, switching resumes through the usual turn-on paths. The restart timer holds at its terminal count while the gate is stopped, so a stall longer than one starter period ends at the first edge after the condition clears.

Top module: `pfc_gate_ctrl`

## Requirements
- R1: If the zero-current flag was armed by a rising edge and then falls, the gate rises at the first clock edge that samples the low level. This holds when the gate is off and no stop condition is present.
- R2: A falling edge of the zero-current flag clears the arm even when it cannot turn the gate on, for example while over-voltage holds the gate off. After that condition clears, the gate stays off until the next rising edge re-arms the flag or the starter fires.
- R3: For the first BLANK_CYC clock edges after turn-on (on-cycle indices 0 to BLANK_CYC-1), the current-reference flag has no effect. If that flag is high throughout, the gate is high for exactly BLANK_CYC+1 cycles.
- R4: After blanking, the gate falls at the first edge where the current-reference flag is high. If the flag first rises at on-cycle index d, with d at least BLANK_CYC, the gate is high for d+1 cycles.
- R5: If the current-reference flag never ends the on-time, the gate falls after exactly MAX_ON_CYC cycles high.
- R6: With no zero-current events, the gate rises every START_CYC cycles, counted from one rise to the next.
- R7: A high saturation-level flag drives the gate low at the next edge and keeps it low for as long as the flag stays high. The flag does not latch: if the starter has expired, the gate rises at the first edge after the flag clears.
- R8: A high over-voltage flag holds the gate low in the same way, and switching resumes once the flag clears.
- R9: A low enable holds the gate low in the same way, and switching resumes when enable returns high.
- R10: While reset is held, the gate is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Global run enable; low stops switching |
| zcd | input | 1 | Zero-current detect comparator flag |
| cs_ref | input | 1 | Sensed switch current is above the multiplier reference |
| cs_sat | input | 1 | Sensed switch current is above the saturation level |
| ovp | input | 1 | Dynamic output over-voltage flag |
| gate | output | 1 | Boost switch gate command |

## Verification
The on-time is swept over every onset of the current-reference flag, from the turn-on cycle to well past the cap. Each measured width shows which bound applies: blanking, the current flag, or the on-time cap. The starter is tested with the zero-current input idle and must give a fixed rise-to-rise spacing. Single zero-current pulses separate a true armed trigger from an edge that a stop condition has consumed. Each stop flag is held on through a live on-time and past the starter period, then released. This confirms that the gate drops at once, that nothing latches, and that the overdue starter restarts switching.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef enum logic {
    PH_OFF = 1'b0,
    PH_ON  = 1'b1
  } pfc_phase_e;
endpackage

// File: rtl/pfc_zcd_arm.sv
module pfc_zcd_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic zcd,
  output logic trig
);
  logic zcd_q;
  logic armed;
  logic rise;
  logic fall;

  assign rise = zcd & ~zcd_q;
  assign fall = ~zcd & zcd_q;
  assign trig = armed & fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zcd_q <= 1'b0;
      armed <= 1'b0;
    end else begin
      zcd_q <= zcd;
      if (rise)      armed <= 1'b1;
      else if (fall) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/pfc_sat_cnt.sv
module pfc_sat_cnt #(
  parameter int TERM = 4,
  parameter int W    = (TERM < 1) ? 1 : $clog2(TERM + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         at_lim
);
  localparam logic [W-1:0] TERM_V = W'(TERM);

  assign at_lim = (cnt == TERM_V);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (!at_lim) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pfc_gate_ctrl.sv
module pfc_gate_ctrl #(
  parameter int BLANK_CYC  = 50,
  parameter int MAX_ON_CYC = 1250,
  parameter int START_CYC  = 16667
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic zcd,
  input  logic cs_ref,
  input  logic cs_sat,
  input  logic ovp,
  output logic gate
);
  import pfc_pkg::*;

  localparam int ON_TERM = MAX_ON_CYC - 1;
  localparam int ST_TERM = START_CYC - 1;
  localparam int ON_W    = (ON_TERM < 1) ? 1 : $clog2(ON_TERM + 1);
  localparam int ST_W    = (ST_TERM < 1) ? 1 : $clog2(ST_TERM + 1);
  localparam logic [ON_W-1:0] BLANK_V = ON_W'(BLANK_CYC);

  pfc_phase_e phase;
  pfc_phase_e phase_nxt;
  logic       trig;
  logic       stop;
  logic       turn_on;
  logic       blank_done;
  logic [ON_W-1:0] on_cnt;
  logic       on_at_lim;
  logic [ST_W-1:0] st_cnt;
  logic       start_due;

  pfc_zcd_arm i_zcd (
    .clk   (clk),
    .rst_n (rst_n),
    .zcd   (zcd),
    .trig  (trig)
  );

  pfc_sat_cnt #(.TERM(ON_TERM), .W(ON_W)) i_on_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (turn_on),
    .cnt    (on_cnt),
    .at_lim (on_at_lim)
  );

  pfc_sat_cnt #(.TERM(ST_TERM), .W(ST_W)) i_starter (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (turn_on),
    .cnt    (st_cnt),
    .at_lim (start_due)
  );

  assign stop       = ~en | ovp | cs_sat;
  assign blank_done = (on_cnt >= BLANK_V);
  assign turn_on    = (phase == PH_OFF) && (phase_nxt == PH_ON);

  always_comb begin
    phase_nxt = phase;
    unique case (phase)
      PH_OFF: if (!stop && (trig || start_due)) phase_nxt = PH_ON;
      PH_ON:  if (stop || (blank_done && cs_ref) || on_at_lim) phase_nxt = PH_OFF;
      default: phase_nxt = PH_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_OFF;
    else        phase <= phase_nxt;
  end

  assign gate = (phase == PH_ON);
endmodule

// File: rtl/pfc_gate_chk.sv
module pfc_gate_chk #(
  parameter int BLANK_CYC  = 50,
  parameter int MAX_ON_CYC = 1250,
  parameter int START_CYC  = 16667
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic zcd,
  input logic cs_ref,
  input logic cs_sat,
  input logic ovp,
  input logic gate
);
  int run;

  always_ff @(posedge clk) begin
    if (!rst_n)                 run <= 0;
    else if (!gate)             run <= 0;
    else if (run <= MAX_ON_CYC) run <= run + 1;
  end

  p_gate_off_reset_r10: assert property (@(posedge clk) !rst_n |=> !gate);
  p_sat_stops_r7: assert property (@(posedge clk) disable iff (!rst_n) cs_sat |=> !gate);
  p_ovp_stops_r8: assert property (@(posedge clk) disable iff (!rst_n) ovp |=> !gate);
  p_en_stops_r9: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !gate);
  p_blank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate) && en && !ovp && !cs_sat) |=> gate);
  p_rise_unstopped_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> $past(en && !ovp && !cs_sat));
  p_on_cap_r5: assert property (@(posedge clk) disable iff (!rst_n) run <= MAX_ON_CYC);
endmodule

bind pfc_gate_ctrl pfc_gate_chk #(
  .BLANK_CYC  (BLANK_CYC),
  .MAX_ON_CYC (MAX_ON_CYC),
  .START_CYC  (START_CYC)
) i_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .en     (en),
  .zcd    (zcd),
  .cs_ref (cs_ref),
  .cs_sat (cs_sat),
  .ovp    (ovp),
  .gate   (gate)
);

// File: tb/test_pfc_gate_ctrl.sv
module test_pfc_gate_ctrl;
  localparam int BLANK = 3;
  localparam int MAXON = 20;
  localparam int START = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic zcd = 1'b0;
  logic cs_ref = 1'b0;
  logic cs_sat = 1'b0;
  logic ovp = 1'b0;
  logic gate;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  pfc_gate_ctrl #(.BLANK_CYC(BLANK), .MAX_ON_CYC(MAXON), .START_CYC(START)) i_pfc_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .zcd(zcd),
    .cs_ref(cs_ref), .cs_sat(cs_sat), .ovp(ovp), .gate(gate)
  );

  always @(negedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog expired: actual %0d cycles expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    int n = 0;
    while (gate && n < 200) begin tick(); n++; end
    while (!gate && n < 200) begin tick(); n++; end
    if (n >= 200) check(1'b0, "wait_rise", n, 0);
  endtask

  task automatic wait_fall();
    int n = 0;
    while (gate && n < 200) begin tick(); n++; end
  endtask

  task automatic stop_case(input int which, input string req);
    int bad = 0;
    cs_ref = 1'b0;
    wait_rise();
    if (which == 0) cs_sat = 1'b1;
    else if (which == 1) ovp = 1'b1;
    else en = 1'b0;
    tick();
    check(gate == 1'b0, req, gate, 0);
    for (int i = 0; i < 60; i++) begin
      tick();
      if (gate) bad++;
    end
    check(bad == 0, req, bad, 0);
    cs_sat = 1'b0; ovp = 1'b0; en = 1'b1;
    tick();
    check(gate == 1'b1, req, gate, 1);
    cs_ref = 1'b1;
    wait_fall();
  endtask

  initial begin
    int w;
    int exp;
    int gap;
    int bad;
    tick(); tick(); tick();
    check(gate == 1'b0, "R10", gate, 0);
    rst_n = 1'b1;

    // R3 R4 R5: on-time sweep over the onset of the current flag
    for (int d = 0; d < 25; d++) begin
      wait_rise();
      cs_ref = (d == 0);
      w = 1;
      forever begin
        tick();
        if (!gate) break;
        cs_ref = (w >= d);
        w++;
      end
      cs_ref = 1'b0;
      exp = ((d > BLANK) ? d : BLANK) + 1;
      if (exp > MAXON) exp = MAXON;
      if (exp == MAXON) check(w == exp, "R5", w, exp);
      else if (d <= BLANK) check(w == exp, "R3", w, exp);
      else check(w == exp, "R4", w, exp);
    end

    // R6: starter spacing with the zero-current input idle
    cs_ref = 1'b1;
    wait_rise();
    for (int p = 0; p < 3; p++) begin
      gap = 0;
      while (gate) begin tick(); gap++; end
      while (!gate) begin tick(); gap++; end
      check(gap == START, "R6", gap, START);
    end

    // R1: armed falling edge turns the gate on at the next edge
    wait_fall();
    zcd = 1'b1; tick(); tick();
    zcd = 1'b0; tick();
    check(gate == 1'b1, "R1", gate, 1);
    wait_fall();
    zcd = 1'b1; tick(); tick(); tick();
    zcd = 1'b0; tick();
    check(gate == 1'b1, "R1", gate, 1);

    // R2: falling edge during over-voltage consumes the arm
    wait_fall();
    zcd = 1'b1; tick();
    ovp = 1'b1; tick();
    zcd = 1'b0; tick(); tick();
    ovp = 1'b0;
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      tick();
      if (gate) bad++;
    end
    check(bad == 0, "R2", bad, 0);
    zcd = 1'b1; tick();
    zcd = 1'b0; tick();
    check(gate == 1'b1, "R2", gate, 1);
    wait_fall();

    stop_case(0, "R7");
    stop_case(1, "R8");
    stop_case(2, "R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule